// File: doc/BRIEF.md
# Cyclic Segmented Prefix Window Logic

This block holds the per-entry status scan for a circular instruction window or reorder buffer. The window is addressed by a head pointer, which marks the oldest entry, and a tail pointer, which marks the first free slot. Both pointers wrap around. Every cycle the block takes per-entry completion, request and destination-match bits and computes three vectors. All three come from prefix scans that begin at the head, wrap from the top index back to index 0, and stop at the head so that nothing passes across that boundary.

The commit vector marks the unbroken run of completed entries that starts at the head. The ready vector tells each entry whether the operand it reads from the tracked register is available. That operand is taken from the nearest older in-range writer of the register, and if there is no such writer the operand comes from the architectural copy and is available. The grant vector selects the oldest requesting entries, up to the number of functional units.

The scans run on head-aligned vectors. A logarithmic barrel rotator aligns the inputs to the head, Kogge-Stone style scans with log2(N) levels do the work, and a second rotator maps the results back. The three result vectors are registered.

Top module: `cwl_window`

## Requirements
- R1: While rst_n is low, and at the first sample after rst_n rises, commit_o, ready_o and grant_o are all zero.
- R2: The outputs are registered. Inputs presented before a rising clock edge are reflected in the outputs after that edge, and a change of inputs between edges does not alter the outputs.
- R3: An entry is in range when its distance from head_i, counted upward modulo N, is less than the occupancy. The occupancy is (tail_i − head_i) mod N, or N when full_i is 1. Entries that are out of range never show commit, ready or grant, and they never act as writers.
- R4: When head_i equals tail_i and full_i is 0, the window is empty and all three outputs are zero. When head_i equals tail_i and full_i is 1, every entry is in range.
- R5: commit_o[i] is 1 exactly when entry i is in range and every entry from the head up to i inclusive has done_i set. The first entry that is not done blocks every younger entry.
- R6: ready_o[i] is 1 when entry i is in range and one of two conditions holds: either no older in-range entry has match_i set, or the nearest older in-range entry with match_i set has done_i set.
- R7: A writer closer to the consumer hides all older writers. A done writer further away does not make the operand ready when a nearer writer is not done, and a nearer done writer makes it ready regardless of older ones.
- R8: grant_o[i] is 1 when entry i is in range, has req_i set, and the number of in-range requesters from the head up to i inclusive is at most NFU. At most NFU grants are ever set.
- R9: The age order wraps. An entry at index 0 is younger than an entry at index N−1 whenever both are in range and the head lies above index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| head_i | input | $clog2(N) | Index of the oldest entry |
| tail_i | input | $clog2(N) | Index of the next free entry |
| full_i | input | 1 | Distinguishes full (1) from empty (0) when head equals tail |
| done_i | input | N | Per-entry completion bit |
| req_i | input | N | Per-entry request for a functional unit |
| match_i | input | N | Per-entry flag: this entry writes the tracked register |
| commit_o | output | N | Entries allowed to retire this cycle |
| ready_o | output | N | Entries whose tracked operand is available |
| grant_o | output | N | Entries granted a functional unit |

## Verification
The bench builds the block with N = 16 and NFU = 2. At this depth random head and tail values often produce runs that wrap past index 15, an empty window and a full window, and a pair of grants often straddles the wrap point. With a two-unit limit, the third and later requesters are denied in most random vectors. The rotators and scan trees still use all four levels, so every shift distance and every combine span is exercised.

// File: rtl/cwl_pkg.sv
package cwl_pkg;
  // saturating add used by the request-count scan
  function automatic int sat_add(input int a, input int b, input int lim);
    int s;
    s = a + b;
    return (s > lim) ? lim : s;
  endfunction

  // distance of an index from the head, modulo a power-of-two depth
  function automatic int age_of(input int idx, input int head, input int n);
    return (idx - head + n) % n;
  endfunction
endpackage

// File: rtl/cwl_rotate.sv
module cwl_rotate #(
  parameter int N    = 128,
  parameter bit LEFT = 1'b0,
  localparam int IW  = $clog2(N)
) (
  input  logic [N-1:0]  d_i,
  input  logic [IW-1:0] sh_i,
  output logic [N-1:0]  q_o
);
  logic [N-1:0] lvl [0:IW];

  generate
    if (LEFT) begin : g_left
      // q[k] = d[(k - sh) mod N]
      always_comb begin
        lvl[0] = d_i;
        for (int s = 0; s < IW; s++) begin
          for (int k = 0; k < N; k++) begin
            lvl[s+1][k] = sh_i[s] ? lvl[s][(k + N - (1 << s)) % N] : lvl[s][k];
          end
        end
      end
    end else begin : g_right
      // q[k] = d[(k + sh) mod N]
      always_comb begin
        lvl[0] = d_i;
        for (int s = 0; s < IW; s++) begin
          for (int k = 0; k < N; k++) begin
            lvl[s+1][k] = sh_i[s] ? lvl[s][(k + (1 << s)) % N] : lvl[s][k];
          end
        end
      end
    end
  endgenerate

  assign q_o = lvl[IW];
endmodule

// File: rtl/cwl_scan_and.sv
module cwl_scan_and #(
  parameter int N = 128,
  localparam int L = $clog2(N)
) (
  input  logic [N-1:0] x_i,
  output logic [N-1:0] y_o
);
  logic [N-1:0] cur, nxt;

  // inclusive prefix AND, log-depth
  always_comb begin
    cur = x_i;
    nxt = x_i;
    for (int s = 0; s < L; s++) begin
      nxt = cur;
      for (int k = (1 << s); k < N; k++) nxt[k] = cur[k] & cur[k - (1 << s)];
      cur = nxt;
    end
    y_o = cur;
  end
endmodule

// File: rtl/cwl_scan_last.sv
module cwl_scan_last #(
  parameter int N = 128,
  localparam int L = $clog2(N)
) (
  input  logic [N-1:0] f_i,
  input  logic [N-1:0] v_i,
  output logic [N-1:0] f_o,
  output logic [N-1:0] v_o
);
  logic [N-1:0] cf, cv, nf, nv;

  // inclusive "nearest flagged element" scan: younger flag wins
  always_comb begin
    cf = f_i;
    cv = v_i;
    nf = f_i;
    nv = v_i;
    for (int s = 0; s < L; s++) begin
      nf = cf;
      nv = cv;
      for (int k = (1 << s); k < N; k++) begin
        if (!cf[k]) begin
          nf[k] = cf[k - (1 << s)];
          nv[k] = cv[k - (1 << s)];
        end
      end
      cf = nf;
      cv = nv;
    end
    f_o = cf;
    v_o = cv;
  end
endmodule

// File: rtl/cwl_scan_cnt.sv
module cwl_scan_cnt #(
  parameter int N   = 128,
  parameter int LIM = 3,
  localparam int L  = $clog2(N),
  localparam int CW = $clog2(LIM + 1)
) (
  input  logic [N-1:0]  x_i,
  output logic [CW-1:0] c_o [N]
);
  logic [CW-1:0] cc [N];
  logic [CW-1:0] nc [N];

  // inclusive saturating population-count prefix
  always_comb begin
    for (int k = 0; k < N; k++) begin
      cc[k] = CW'(x_i[k]);
      nc[k] = cc[k];
    end
    for (int s = 0; s < L; s++) begin
      for (int k = 0; k < N; k++) nc[k] = cc[k];
      for (int k = (1 << s); k < N; k++)
        nc[k] = CW'(cwl_pkg::sat_add(int'(cc[k]), int'(cc[k - (1 << s)]), LIM));
      for (int k = 0; k < N; k++) cc[k] = nc[k];
    end
    for (int k = 0; k < N; k++) c_o[k] = cc[k];
  end
endmodule

// File: rtl/cwl_window.sv
module cwl_window #(
  parameter int N   = 128,
  parameter int NFU = 2,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] head_i,
  input  logic [IW-1:0] tail_i,
  input  logic          full_i,
  input  logic [N-1:0]  done_i,
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  match_i,
  output logic [N-1:0]  commit_o,
  output logic [N-1:0]  ready_o,
  output logic [N-1:0]  grant_o
);
  localparam int LIM = NFU + 1;
  localparam int CW  = $clog2(LIM + 1);

  // head-aligned views: index 0 is the oldest entry
  logic [N-1:0]  al_done, al_req, al_match;
  logic [N-1:0]  al_inr;
  logic [IW-1:0] occ_w;
  logic [N-1:0]  run_w, wf_w, wv_w;
  logic [CW-1:0] cnt_w [N];
  logic [N-1:0]  al_commit, al_ready, al_grant;
  logic [N-1:0]  nx_commit, nx_ready, nx_grant;

  cwl_rotate #(.N(N), .LEFT(1'b0)) u_al_done  (.d_i(done_i),  .sh_i(head_i), .q_o(al_done));
  cwl_rotate #(.N(N), .LEFT(1'b0)) u_al_req   (.d_i(req_i),   .sh_i(head_i), .q_o(al_req));
  cwl_rotate #(.N(N), .LEFT(1'b0)) u_al_match (.d_i(match_i), .sh_i(head_i), .q_o(al_match));

  assign occ_w = tail_i - head_i;

  always_comb begin
    for (int k = 0; k < N; k++) al_inr[k] = full_i | (k < int'(occ_w));
  end

  cwl_scan_and #(.N(N)) u_commit_scan (.x_i(al_inr & al_done), .y_o(run_w));

  cwl_scan_last #(.N(N)) u_writer_scan (
    .f_i(al_inr & al_match), .v_i(al_done), .f_o(wf_w), .v_o(wv_w)
  );

  cwl_scan_cnt #(.N(N), .LIM(LIM)) u_req_scan (.x_i(al_inr & al_req), .c_o(cnt_w));

  always_comb begin
    al_commit = run_w;
    al_ready[0] = al_inr[0];
    for (int k = 1; k < N; k++)
      al_ready[k] = al_inr[k] & (wf_w[k-1] ? wv_w[k-1] : 1'b1);
    for (int k = 0; k < N; k++)
      al_grant[k] = al_inr[k] & al_req[k] & (int'(cnt_w[k]) <= NFU);
  end

  cwl_rotate #(.N(N), .LEFT(1'b1)) u_bk_commit (.d_i(al_commit), .sh_i(head_i), .q_o(nx_commit));
  cwl_rotate #(.N(N), .LEFT(1'b1)) u_bk_ready  (.d_i(al_ready),  .sh_i(head_i), .q_o(nx_ready));
  cwl_rotate #(.N(N), .LEFT(1'b1)) u_bk_grant  (.d_i(al_grant),  .sh_i(head_i), .q_o(nx_grant));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_o <= '0;
      ready_o  <= '0;
      grant_o  <= '0;
    end else begin
      commit_o <= nx_commit;
      ready_o  <= nx_ready;
      grant_o  <= nx_grant;
    end
  end
endmodule

// File: rtl/cwl_window_chk.sv
module cwl_window_chk #(
  parameter int N   = 128,
  parameter int NFU = 2,
  localparam int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [IW-1:0] head_i,
  input logic [IW-1:0] tail_i,
  input logic          full_i,
  input logic [N-1:0]  done_i,
  input logic [N-1:0]  req_i,
  input logic [N-1:0]  commit_o,
  input logic [N-1:0]  ready_o,
  input logic [N-1:0]  grant_o
);
  logic [N-1:0]  in_range_w;
  logic [IW-1:0] occ_w;
  logic          empty_w;

  assign occ_w   = tail_i - head_i;
  assign empty_w = (head_i == tail_i) && !full_i;

  always_comb begin
    for (int i = 0; i < N; i++)
      in_range_w[i] = full_i | (cwl_pkg::age_of(i, int'(head_i), N) < int'(occ_w));
  end

  AST_GRANT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant_o) <= NFU); // R8

  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(empty_w) |-> (commit_o == '0 && ready_o == '0 && grant_o == '0)); // R4

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_ent
      localparam int PREV = (gi + N - 1) % N;

      AST_COMMIT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o[gi] |-> $past(done_i[gi])); // R5

      AST_COMMIT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o[gi] && int'($past(head_i)) != gi) |-> commit_o[PREV]); // R9

      AST_GRANT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o[gi] |-> $past(req_i[gi])); // R8

      AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!in_range_w[gi]) |-> !(commit_o[gi] || ready_o[gi] || grant_o[gi])); // R3
    end
  endgenerate
endmodule

bind cwl_window cwl_window_chk #(.N(N), .NFU(NFU)) u_chk (
  .clk(clk), .rst_n(rst_n), .head_i(head_i), .tail_i(tail_i), .full_i(full_i),
  .done_i(done_i), .req_i(req_i), .commit_o(commit_o), .ready_o(ready_o),
  .grant_o(grant_o)
);

// File: tb/cwl_window_tb.sv
`timescale 1ns/1ps
module cwl_window_tb;
  localparam int N   = 16;
  localparam int NFU = 2;
  localparam int IW  = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [IW-1:0] head = '0, tail = '0;
  logic          full = 1'b0;
  logic [N-1:0]  done = '0, req = '0, match = '0;
  logic [N-1:0]  commit_o, ready_o, grant_o;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] exp_c = '0, exp_r = '0, exp_g = '0;

  always #2.5 clk = ~clk;

  cwl_window #(.N(N), .NFU(NFU)) u_dut (
    .clk(clk), .rst_n(rst_n), .head_i(head), .tail_i(tail), .full_i(full),
    .done_i(done), .req_i(req), .match_i(match),
    .commit_o(commit_o), .ready_o(ready_o), .grant_o(grant_o)
  );

  // behavioural reference: walk from the head in age order
  task automatic model(input int h, input int t, input bit f,
                       input logic [N-1:0] d, input logic [N-1:0] r,
                       input logic [N-1:0] m);
    int  occ, cnt, idx;
    bit  all_done, seen_w, w_done;
    occ = f ? N : (t - h + N) % N;
    all_done = 1; seen_w = 0; w_done = 0; cnt = 0;
    exp_c = '0; exp_r = '0; exp_g = '0;
    for (int k = 0; k < occ; k++) begin
      idx = (h + k) % N;
      exp_r[idx] = seen_w ? w_done : 1'b1;
      all_done = all_done & d[idx];
      exp_c[idx] = all_done;
      if (r[idx]) begin
        cnt++;
        exp_g[idx] = (cnt <= NFU);
      end
      if (m[idx]) begin
        seen_w = 1;
        w_done = d[idx];
      end
    end
  endtask

  task automatic cmp(input string tag, input string what,
                     input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cmp_all(input string tag);
    cmp(tag == "" ? "R5" : tag, "commit", commit_o, exp_c);
    cmp(tag == "" ? "R6" : tag, "ready",  ready_o,  exp_r);
    cmp(tag == "" ? "R8" : tag, "grant",  grant_o,  exp_g);
  endtask

  // drive at negedge, confirm hold before the edge, compare at next negedge
  task automatic apply(input int h, input int t, input bit f,
                       input logic [N-1:0] d, input logic [N-1:0] r,
                       input logic [N-1:0] m, input string tag);
    head = IW'(h); tail = IW'(t); full = f;
    done = d; req = r; match = m;
    #1;
    cmp_all("R2");
    model(h, t, f, d, r, m);
    @(negedge clk);
    cmp_all(tag);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: outputs zero during and just after reset, inputs active
    head = 4'd3; tail = 4'd9; done = '1; req = '1; match = '1;
    repeat (3) @(negedge clk);
    cmp_all("R1");
    rst_n = 1'b1;
    head = '0; tail = '0; done = '0; req = '0; match = '0;
    @(negedge clk);
    cmp_all("R1");

    // R4: empty window, everything set
    apply(5, 5, 1'b0, '1, '1, '1, "R4");
    // R4: full window, all done
    apply(5, 5, 1'b1, '1, '1, '0, "R4");
    // R3: partial range, out-of-range bits set
    apply(2, 6, 1'b0, '1, '1, 16'h0000, "R3");
    apply(2, 6, 1'b0, 16'hFFF3, 16'hFF03, 16'hFFC0, "R3");
    // R9: range wraps through index 0
    apply(14, 3, 1'b0, '1, 16'h8001, 16'h0000, "R9");
    apply(14, 3, 1'b0, 16'hBFFF, 16'hC003, 16'h4000, "R9");
    // R7: near undone writer hides far done writer
    apply(0, 8, 1'b0, 16'h00EF, 16'h0000, 16'h0012, "R7");
    // R7: near done writer hides far undone writer
    apply(0, 8, 1'b0, 16'h0010, 16'h0000, 16'h0012, "R7");
    // R5: blocking by first not-done entry
    apply(9, 15, 1'b0, 16'hFDFF, 16'h0000, 16'h0000, "R5");
    // R8: grants stop at NFU across wrap
    apply(12, 12, 1'b1, '0, 16'h9001, 16'h0000, "R8");
    // R6: writer at the head, consumer right after
    apply(7, 10, 1'b0, 16'h0000, 16'h0000, 16'h0080, "R6");

    for (int n = 0; n < 3000; n++) begin
      apply(int'($urandom_range(N - 1)), int'($urandom_range(N - 1)),
            ($urandom_range(3) == 0),
            N'($urandom), N'($urandom), N'($urandom & $urandom), "");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule